// File: doc/BRIEF.md
# SEC-DED Hamming Codec for Byte Data

This block protects one byte with an extended Hamming code. Its encoder is purely combinational. It turns an 8-bit byte into a 13-bit codeword. The low twelve bits carry a position-numbered Hamming word, with check bits at the power-of-two positions. The top bit carries parity over those twelve bits.

The checker takes a 13-bit codeword together with a valid strobe. One clock later it presents the following:

- the recovered byte;
- the four-bit syndrome;
- a flag for a corrected single error;
- a flag for an uncorrectable error.

Because of the position numbering, the syndrome names the failing bit position directly. The decision therefore needs only a range compare and a one-hot flip.

A typical user encodes before a store and checks after a load. The two flags steer retry or fault handling. The checker results stay on its outputs until the next valid input arrives.

Top module: `secded_codec`

## Requirements
- R1: Codeword bit index i-1 holds Hamming position i, for positions 1 to 12. Data bit 0 goes to position 3, and the remaining data bits take positions 5, 6, 7, 9, 10, 11 and 12 in ascending order.
- R2: The check bit at position 2^k (k = 0..3) makes the even parity over every position 1..12 whose index has bit k set.
- R3: Codeword bit 12 is the even parity over codeword bits 11..0.
- R4: After a cycle with `chk_valid_i` high, `chk_valid_o` is high one cycle later, and the results belong to that input. While `chk_valid_i` is low, the data, syndrome and flag outputs keep their values, and `chk_valid_o` is low.
- R5: The syndrome bit k is the XOR of all received bits at positions 1..12 whose index has bit k set. Bit 3 is the MSB.
- R6: A codeword fresh from the encoder yields syndrome 0, both flags low, and the original byte.
- R7: A single flipped bit at position p (1..12) yields syndrome p and `chk_single_o` = 1, and the byte is corrected.
- R8: A flip in bit 12 alone yields syndrome 0 and `chk_single_o` = 1, and the byte is unchanged.
- R9: When the syndrome is nonzero and the overall parity passes, the result is `chk_double_o` = 1 and `chk_single_o` = 0. The byte is the uncorrected data found at the data positions. The two flags are never high together.
- R10: When the syndrome is 13, 14 or 15 and the overall parity fails, the result is `chk_double_o` = 1 and `chk_single_o` = 0, and the byte is left uncorrected.
- R11: The synchronous active-high reset `rst` clears `chk_valid_o`, the byte, the syndrome and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_data_i | input | 8 | Byte to encode |
| enc_code_o | output | 13 | Encoded codeword (combinational) |
| chk_valid_i | input | 1 | Codeword on `chk_code_i` is to be checked |
| chk_code_i | input | 13 | Received codeword |
| chk_valid_o | output | 1 | Result registered this cycle |
| chk_data_o | output | 8 | Recovered byte |
| chk_syndrome_o | output | 4 | Syndrome {C8,C4,C2,C1} |
| chk_single_o | output | 1 | Single error corrected (or check-parity bit hit) |
| chk_double_o | output | 1 | Uncorrectable error detected |

## Verification
The hardest outcome to reach is a syndrome of 13 to 15 together with a failing overall parity. No single-bit or double-bit fault on a valid codeword can produce it. The bench reaches it with deliberate triple flips: check positions 1, 4 and 8 give syndrome 13, 2, 4 and 8 give 14, and 3, 4 and 8 give 15. These triples are applied for every byte value. Around this case the bench also sweeps every byte through all single flips and all 78 double flips. This covers the flip of the overall parity bit alone, whose zero syndrome must still raise the single flag.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W = 8;
    localparam int PAR_W  = 4;
    localparam int HAM_W  = DATA_W + PAR_W;
    localparam int CW_W   = HAM_W + 1;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [PAR_W-1:0]  syn;
        logic              single;
        logic              dbl;
    } chk_state_t;

    // 1-based Hamming position of data bit j (skips power-of-two slots)
    function automatic int data_pos(input int j);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p <= HAM_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == j) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Positions covered by check bit k
    function automatic logic [HAM_W-1:0] group_mask(input int k);
        logic [HAM_W-1:0] m;
        m = '0;
        for (int p = 1; p <= HAM_W; p++) begin
            if (((p >> k) & 1) == 1) m[p-1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   code_o
);

    logic [HAM_W-1:0] ham;

    always_comb begin
        ham = '0;
        for (int j = 0; j < DATA_W; j++) begin
            ham[data_pos(j)-1] = data_i[j];
        end
        // check slots are still zero here, so each group sum sees only data
        for (int k = 0; k < PAR_W; k++) begin
            ham[(1 << k)-1] = ^(ham & group_mask(k));
        end
    end

    assign code_o = {^ham, ham};

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
    import secded_pkg::*;
(
    input  logic [CW_W-1:0]  code_i,
    output logic [PAR_W-1:0] syn_o,
    output logic             perr_o
);

    for (genvar k = 0; k < PAR_W; k++) begin : g_syn
        localparam logic [HAM_W-1:0] GRP = group_mask(k);
        assign syn_o[k] = ^(code_i[HAM_W-1:0] & GRP);
    end

    assign perr_o = ^code_i;

endmodule

// File: rtl/secded_corrector.sv
module secded_corrector
    import secded_pkg::*;
(
    input  logic [CW_W-1:0]   code_i,
    input  logic [PAR_W-1:0]  syn_i,
    input  logic              fix_i,
    output logic [DATA_W-1:0] data_o
);

    logic [HAM_W-1:0] flip;
    logic [HAM_W-1:0] fixed;

    for (genvar p = 1; p <= HAM_W; p++) begin : g_flip
        assign flip[p-1] = fix_i && (int'(syn_i) == p);
    end

    assign fixed = code_i[HAM_W-1:0] ^ flip;

    for (genvar j = 0; j < DATA_W; j++) begin : g_ext
        localparam int POS = data_pos(j);
        assign data_o[j] = fixed[POS-1];
    end

endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CW_W-1:0]   enc_code_o,
    input  logic              chk_valid_i,
    input  logic [CW_W-1:0]   chk_code_i,
    output logic              chk_valid_o,
    output logic [DATA_W-1:0] chk_data_o,
    output logic [PAR_W-1:0]  chk_syndrome_o,
    output logic              chk_single_o,
    output logic              chk_double_o
);

    chk_state_t state_d, state_q;

    logic [PAR_W-1:0]  syn;
    logic              perr;
    logic              syn_zero;
    logic              in_range;
    logic              fix;
    logic [DATA_W-1:0] data_fixed;

    secded_encoder u_enc (
        .data_i (enc_data_i),
        .code_o (enc_code_o)
    );

    secded_syndrome u_syn (
        .code_i (chk_code_i),
        .syn_o  (syn),
        .perr_o (perr)
    );

    assign syn_zero = (syn == '0);
    assign in_range = (int'(syn) <= HAM_W);
    assign fix      = perr && !syn_zero && in_range;

    secded_corrector u_cor (
        .code_i (chk_code_i),
        .syn_i  (syn),
        .fix_i  (fix),
        .data_o (data_fixed)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = chk_valid_i;
        if (chk_valid_i) begin
            state_d.data   = data_fixed;
            state_d.syn    = syn;
            state_d.single = perr && (syn_zero || in_range);
            state_d.dbl    = !syn_zero && (!perr || !in_range);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign chk_valid_o    = state_q.valid;
    assign chk_data_o     = state_q.data;
    assign chk_syndrome_o = state_q.syn;
    assign chk_single_o   = state_q.single;
    assign chk_double_o   = state_q.dbl;

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] enc_data_i,
    input  logic [CW_W-1:0]   enc_code_o,
    input  logic              chk_valid_i,
    input  logic [CW_W-1:0]   chk_code_i,
    input  logic              chk_valid_o,
    input  logic [DATA_W-1:0] chk_data_o,
    input  logic [PAR_W-1:0]  chk_syndrome_o,
    input  logic              chk_single_o,
    input  logic              chk_double_o
);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(chk_single_o && chk_double_o)); // R9

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        chk_valid_i |=> chk_valid_o); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !chk_valid_i |=> !chk_valid_o && $stable(chk_data_o) && $stable(chk_syndrome_o)
                          && $stable(chk_single_o) && $stable(chk_double_o)); // R4

    AST_ROUNDTRIP_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (chk_valid_i && chk_code_i == enc_code_o) |=>
        (!chk_single_o && !chk_double_o && chk_syndrome_o == '0
         && chk_data_o == $past(enc_data_i))); // R6

    AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
        (chk_valid_o && int'(chk_syndrome_o) > HAM_W) |-> chk_double_o); // R10

    AST_ZERO_SYN_NO_DOUBLE: assert property (@(posedge clk) disable iff (rst)
        (chk_valid_o && chk_syndrome_o == '0) |-> !chk_double_o); // R8

endmodule

bind secded_codec secded_codec_chk u_chk (.*);

// File: tb/tb_secded_codec.sv
module tb_secded_codec;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  enc_data_i;
    logic [12:0] enc_code_o;
    logic        chk_valid_i;
    logic [12:0] chk_code_i;
    logic        chk_valid_o;
    logic [7:0]  chk_data_o;
    logic [3:0]  chk_syndrome_o;
    logic        chk_single_o;
    logic        chk_double_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    secded_codec dut (.*);

    function automatic bit is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // place data bits in ascending non-power-of-two positions
    function automatic logic [12:0] ref_encode(input logic [7:0] d);
        logic [12:0] c;
        int j;
        c = '0;
        j = 0;
        for (int p = 1; p <= 12; p++) begin
            if (!is_pow2(p)) begin
                c[p-1] = d[j];
                j++;
            end
        end
        for (int k = 0; k < 4; k++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p <= 12; p++) begin
                if (((p >> k) & 1) == 1 && p != (1 << k)) par ^= c[p-1];
            end
            c[(1 << k)-1] = par;
        end
        c[12] = ^c[11:0];
        return c;
    endfunction

    function automatic logic [7:0] ref_extract(input logic [12:0] c);
        logic [7:0] d;
        int j;
        j = 0;
        d = '0;
        for (int p = 1; p <= 12; p++) begin
            if (!is_pow2(p)) begin
                d[j] = c[p-1];
                j++;
            end
        end
        return d;
    endfunction

    function automatic int pos_of(input int bitidx);
        return (bitidx < 12) ? bitidx + 1 : 0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [12:0] c);
        @(negedge clk);
        chk_valid_i = 1'b1;
        chk_code_i  = c;
        @(negedge clk);
        chk_valid_i = 1'b0;
    endtask

    function automatic logic [14:0] pack_out(input logic v, input logic s, input logic dd,
                                             input logic [3:0] sy, input logic [7:0] d);
        return {v, s, dd, sy, d};
    endfunction

    task automatic check_result(input string req, input logic [3:0] syn, input logic s,
                                input logic dd, input logic [7:0] d);
        logic [14:0] act, exp;
        act = pack_out(chk_valid_o, chk_single_o, chk_double_o, chk_syndrome_o, chk_data_o);
        exp = pack_out(1'b1, s, dd, syn, d);
        check(act == exp, req, 32'(act), 32'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 300000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [12:0] cw, rx;
        logic [14:0] held;
        rst = 1'b1;
        enc_data_i = '0;
        chk_valid_i = 1'b0;
        chk_code_i = '0;
        repeat (3) @(negedge clk);
        // R11: cleared state while in reset
        check({chk_valid_o, chk_single_o, chk_double_o, chk_syndrome_o, chk_data_o} == '0,
              "R11 reset", 32'({chk_valid_o, chk_single_o, chk_double_o, chk_syndrome_o, chk_data_o}), 0);
        rst = 1'b0;

        for (int d = 0; d < 256; d++) begin
            enc_data_i = 8'(d);
            #1;
            cw = ref_encode(8'(d));
            check(ref_extract(enc_code_o) == 8'(d), "R1 data layout", 32'(enc_code_o), 32'(cw));
            check(enc_code_o[11:0] == cw[11:0], "R2 check bits", 32'(enc_code_o), 32'(cw));
            check(enc_code_o[12] == ^enc_code_o[11:0], "R3 overall parity",
                  32'(enc_code_o[12]), 32'(^enc_code_o[11:0]));

            apply(cw);
            check_result("R6 clean", 4'd0, 1'b0, 1'b0, 8'(d));

            for (int e = 0; e < 13; e++) begin
                rx = cw ^ (13'd1 << e);
                apply(rx);
                if (e == 12) check_result("R8 parity bit only", 4'd0, 1'b1, 1'b0, 8'(d));
                else         check_result("R7 R5 single corrected", 4'(e + 1), 1'b1, 1'b0, 8'(d));
            end

            for (int a = 0; a < 13; a++) begin
                for (int b = a + 1; b < 13; b++) begin
                    rx = cw ^ (13'd1 << a) ^ (13'd1 << b);
                    apply(rx);
                    check_result("R9 R5 double", 4'(pos_of(a) ^ pos_of(b)), 1'b0, 1'b1,
                                 ref_extract(rx));
                end
            end

            // R10: triples reaching syndromes 13, 14, 15 with failing parity
            for (int t = 0; t < 3; t++) begin
                rx = cw ^ (13'd1 << t) ^ (13'd1 << 3) ^ (13'd1 << 7);
                apply(rx);
                check_result("R10 out of range", 4'((t + 1) ^ 4 ^ 8), 1'b0, 1'b1, ref_extract(rx));
            end
        end

        // R4: outputs hold while valid is low, valid_o drops
        cw = ref_encode(8'hA5) ^ 13'h0010;
        apply(cw);
        held = pack_out(1'b0, chk_single_o, chk_double_o, chk_syndrome_o, chk_data_o);
        @(negedge clk);
        chk_code_i = 13'h1FFF;
        repeat (2) @(negedge clk);
        check(pack_out(chk_valid_o, chk_single_o, chk_double_o, chk_syndrome_o, chk_data_o) == held,
              "R4 hold idle",
              32'(pack_out(chk_valid_o, chk_single_o, chk_double_o, chk_syndrome_o, chk_data_o)),
              32'(held));
        check(held == pack_out(1'b0, 1'b1, 1'b0, 4'd5, 8'hA5), "R4 R7 held value",
              32'(held), 32'(pack_out(1'b0, 1'b1, 1'b0, 4'd5, 8'hA5)));

        // R11: reset mid-run clears a nonzero result
        apply(ref_encode(8'h3C) ^ 13'h0003);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check({chk_valid_o, chk_single_o, chk_double_o, chk_syndrome_o, chk_data_o} == '0,
              "R11 reset mid-run",
              32'({chk_valid_o, chk_single_o, chk_double_o, chk_syndrome_o, chk_data_o}), 0);
        rst = 1'b0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule